// File: doc/BRIEF.md
# H-Bridge Phase Control with Blanking

This block drives the four gate enables of one DC motor H-bridge: the high-side and low-side switch of the positive output and of the negative output. A sleep input, an enable input and a direction (phase) input select the switch pattern. Two fault inputs, motor over-current and thermal shutdown, force every switch off without delay. When the direction changes, all switches are first held off for a dead-time count, and only then is the new direction driven.

A chopping timer derives an oscillator tick from the system clock, with a period picked by a 2-bit code. Every eighth tick starts a new chopping cycle. A blanking window opens at each chopping-cycle start and at each direction reversal. Its length is picked by a second 2-bit code. While the window is open, the current-trip comparator input is ignored. Outside the window, a trip switches the bridge off until the next chopping-cycle start. All durations are counted in system-clock cycles and are set by parameters, one per code.

Top module: `hbridge_blank_ctrl`

## Requirements
- R1: When `sleep_n` is 0 or `enable` is 0, all four switch enables are 0 in the same cycle.
- R2: When the bridge is driven, registered phase 0 turns on `pos_ls` and `neg_hs`, and registered phase 1 turns on `pos_hs` and `neg_ls`. The registered phase is the `phase` input captured at the previous clock edge.
- R3: When `ocp_kill` or `tsd_kill` is 1, all four switch enables are 0 in the same cycle, whatever the other inputs are.
- R4: A started blanking window keeps `blank_active` at 1 for exactly the number of cycles chosen by `blank_code`: 00 selects BLANK_00 (default 3.75 us), 01 selects BLANK_01 (2.50 us), 10 selects BLANK_10 (5.00 us), and 11 selects BLANK_11 (6.25 us). A new start reloads the full length.
- R5: A blanking window starts at the clock edge after `phase` differs from the registered phase, and at the clock edge that ends a cycle in which `chop_start` is 1.
- R6: An oscillator tick happens every N cycles, where `chop_code` selects N: 00 selects OSC_DIV_00 (100 kHz chopping by default), 01 selects OSC_DIV_01 (50 kHz), 10 selects OSC_DIV_10 (133 kHz), and 11 selects OSC_DIV_11 (200 kHz). `chop_start` is 1 for one cycle on every eighth tick, so chopping cycles are 8*N cycles apart.
- R7: `trip_masked` equals `trip_raw` when `blank_active` is 0, and is 0 while `blank_active` is 1.
- R8: When `trip_masked` is 1 in a cycle where `chop_start` is 0, all switch enables are 0 from the next cycle until the cycle after the next `chop_start`.
- R9: After a reversal, all switch enables stay 0 for DEAD_CYC cycles (DEAD_CYC at least 1) before the new direction is driven.
- R10: The high-side and low-side enable of the same output are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | 0 puts the bridge to sleep (all switches off) |
| enable | input | 1 | Drive enable |
| phase | input | 1 | Direction request |
| ocp_kill | input | 1 | Motor over-current fault |
| tsd_kill | input | 1 | Thermal shutdown fault |
| trip_raw | input | 1 | Current-trip comparator output |
| blank_code | input | 2 | Blanking length select |
| chop_code | input | 2 | Chopping frequency select |
| pos_hs | output | 1 | Positive output, high-side enable |
| pos_ls | output | 1 | Positive output, low-side enable |
| neg_hs | output | 1 | Negative output, high-side enable |
| neg_ls | output | 1 | Negative output, low-side enable |
| blank_active | output | 1 | Blanking window open |
| trip_masked | output | 1 | Trip input after blanking |
| chop_start | output | 1 | One-cycle pulse at each chopping-cycle start |

## Verification
The assertions check several properties on every cycle:
- Shoot-through freedom on each output.
- The immediate switch-off on sleep, disable and faults.
- Masking of the trip input while blanking is open.
- That a blanking window follows each chopping-cycle start.
- That an unmasked trip leaves the bridge off in the next cycle.
- That the driven direction never flips between two consecutive driven cycles.

The exact window lengths for each code, the chopping period for each code, the dead-time count and the release of a trip latch at the next cycle start depend on counts. Only the bench's reference model and its directed length measurements can show these.

// File: rtl/hbridge_blank_ctrl.sv
module hbridge_blank_ctrl #(
  parameter int unsigned OSC_DIV_00 = 156,
  parameter int unsigned OSC_DIV_01 = 312,
  parameter int unsigned OSC_DIV_10 = 117,
  parameter int unsigned OSC_DIV_11 = 78,
  parameter int unsigned BLANK_00   = 469,
  parameter int unsigned BLANK_01   = 312,
  parameter int unsigned BLANK_10   = 625,
  parameter int unsigned BLANK_11   = 781,
  parameter int unsigned DEAD_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       enable,
  input  logic       phase,
  input  logic       ocp_kill,
  input  logic       tsd_kill,
  input  logic       trip_raw,
  input  logic [1:0] blank_code,
  input  logic [1:0] chop_code,
  output logic       pos_hs,
  output logic       pos_ls,
  output logic       neg_hs,
  output logic       neg_ls,
  output logic       blank_active,
  output logic       trip_masked,
  output logic       chop_start
);

  function automatic int unsigned max4(int unsigned a, int unsigned b, int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  localparam int unsigned OSC_MAX = max4(OSC_DIV_00, OSC_DIV_01, OSC_DIV_10, OSC_DIV_11);
  localparam int unsigned BLK_MAX = max4(BLANK_00, BLANK_01, BLANK_10, BLANK_11);
  localparam int OSC_W  = $clog2(OSC_MAX + 1);
  localparam int BLK_W  = $clog2(BLK_MAX + 1);
  localparam int DEAD_W = $clog2(DEAD_CYC + 1);

  logic [OSC_W-1:0]  osc_cnt, osc_div;
  logic [2:0]        tick_cnt;
  logic [BLK_W-1:0]  blank_cnt, blank_len;
  logic [DEAD_W-1:0] dead_cnt;
  logic              phase_q, trip_off, osc_tick, reversal, drive_on;

  always_comb begin
    case (chop_code)
      2'b00:   osc_div = OSC_W'(OSC_DIV_00);
      2'b01:   osc_div = OSC_W'(OSC_DIV_01);
      2'b10:   osc_div = OSC_W'(OSC_DIV_10);
      default: osc_div = OSC_W'(OSC_DIV_11);
    endcase
    case (blank_code)
      2'b00:   blank_len = BLK_W'(BLANK_00);
      2'b01:   blank_len = BLK_W'(BLANK_01);
      2'b10:   blank_len = BLK_W'(BLANK_10);
      default: blank_len = BLK_W'(BLANK_11);
    endcase
  end

  assign osc_tick     = osc_cnt >= osc_div - OSC_W'(1);
  assign chop_start   = osc_tick && tick_cnt == 3'd7;
  assign reversal     = phase != phase_q;
  assign blank_active = blank_cnt != '0;
  assign trip_masked  = trip_raw && !blank_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_cnt  <= '0;
      tick_cnt <= '0;
    end else if (osc_tick) begin
      osc_cnt  <= '0;
      tick_cnt <= tick_cnt + 3'd1;
    end else begin
      osc_cnt  <= osc_cnt + OSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      dead_cnt  <= '0;
      blank_cnt <= '0;
      trip_off  <= 1'b0;
    end else begin
      phase_q <= phase;
      if (reversal)               dead_cnt <= DEAD_W'(DEAD_CYC);
      else if (dead_cnt != '0)    dead_cnt <= dead_cnt - DEAD_W'(1);
      if (reversal || chop_start) blank_cnt <= blank_len;
      else if (blank_active)      blank_cnt <= blank_cnt - BLK_W'(1);
      if (chop_start)             trip_off <= 1'b0;
      else if (trip_masked)       trip_off <= 1'b1;
    end
  end

  assign drive_on = sleep_n && enable && !ocp_kill && !tsd_kill && dead_cnt == '0 && !trip_off;
  assign pos_hs   = drive_on &&  phase_q;
  assign neg_ls   = drive_on &&  phase_q;
  assign pos_ls   = drive_on && !phase_q;
  assign neg_hs   = drive_on && !phase_q;

endmodule

// File: rtl/hbridge_blank_ctrl_chk.sv
module hbridge_blank_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_n,
  input logic enable,
  input logic phase,
  input logic ocp_kill,
  input logic tsd_kill,
  input logic pos_hs,
  input logic pos_ls,
  input logic neg_hs,
  input logic neg_ls,
  input logic blank_active,
  input logic trip_masked,
  input logic chop_start
);
  logic armed;
  logic any_on;
  assign any_on = pos_hs || pos_ls || neg_hs || neg_ls;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pos_hs, pos_ls}) && $onehot0({neg_hs, neg_ls}));

  assert_sleep_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n || !enable) |-> !any_on);

  assert_fault_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_kill || tsd_kill) |-> !any_on);

  assert_blank_masks_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_active |-> !trip_masked);

  assert_chop_opens_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chop_start |=> blank_active);

  assert_trip_cuts_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(trip_masked) && !$past(chop_start)) |-> !any_on);

  assert_no_direct_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && any_on && $past(any_on)) |-> $stable(pos_hs));
endmodule

bind hbridge_blank_ctrl hbridge_blank_ctrl_chk u_chk (.*);

// File: tb/hbridge_blank_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_blank_ctrl_test;
  localparam int OD0 = 5, OD1 = 9, OD2 = 4, OD3 = 3;
  localparam int BL0 = 7, BL1 = 5, BL2 = 9, BL3 = 11;
  localparam int DEAD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_n = 1'b0, enable = 1'b0, phase = 1'b0, ocp_kill = 1'b0, tsd_kill = 1'b0, trip_raw = 1'b0;
  logic [1:0] blank_code = 2'b00, chop_code = 2'b00;
  logic pos_hs, pos_ls, neg_hs, neg_ls, blank_active, trip_masked, chop_start;

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_osc, m_tick, m_dead, m_blank;
  bit m_phq, m_trip;

  always #4 clk = ~clk;

  hbridge_blank_ctrl #(
    .OSC_DIV_00(OD0), .OSC_DIV_01(OD1), .OSC_DIV_10(OD2), .OSC_DIV_11(OD3),
    .BLANK_00(BL0), .BLANK_01(BL1), .BLANK_10(BL2), .BLANK_11(BL3), .DEAD_CYC(DEAD)
  ) uut (.*);

  function automatic int osc_div(logic [1:0] c);
    return c == 2'b00 ? OD0 : c == 2'b01 ? OD1 : c == 2'b10 ? OD2 : OD3;
  endfunction

  function automatic int blank_len(logic [1:0] c);
    return c == 2'b00 ? BL0 : c == 2'b01 ? BL1 : c == 2'b10 ? BL2 : BL3;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_osc = 0; m_tick = 0; m_dead = 0; m_blank = 0; m_phq = 0; m_trip = 0;
  endtask

  // compare outputs with the model, then advance the model across one edge
  task automatic step();
    bit tick, cs, bact, tm, on, rev;
    string req;
    #1;
    tick = m_osc >= osc_div(chop_code) - 1;
    cs   = tick && m_tick == 7;
    bact = m_blank != 0;
    tm   = trip_raw && !bact;
    on   = sleep_n && enable && !ocp_kill && !tsd_kill && m_dead == 0 && !m_trip;
    if (!sleep_n || !enable)      req = "R1";
    else if (ocp_kill || tsd_kill) req = "R3";
    else if (m_dead != 0)         req = "R9";
    else if (m_trip)              req = "R8";
    else                          req = "R2";
    check(req, {pos_hs, pos_ls, neg_hs, neg_ls}, {on && m_phq, on && !m_phq, on && !m_phq, on && m_phq});
    check("R4 R5", blank_active, bact);
    check("R6", chop_start, cs);
    check("R7", trip_masked, tm);
    @(posedge clk);
    rev = phase != m_phq;
    if (tick) begin m_osc = 0; m_tick = (m_tick + 1) % 8; end
    else m_osc++;
    m_phq = phase;
    if (rev) m_dead = DEAD; else if (m_dead != 0) m_dead--;
    if (rev || cs) m_blank = blank_len(blank_code); else if (m_blank != 0) m_blank--;
    if (cs) m_trip = 0; else if (tm) m_trip = 1;
    @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] bc, logic [1:0] cc);
    @(negedge clk);
    rst_n = 1'b0; blank_code = bc; chop_code = cc;
    sleep_n = 1'b1; enable = 1'b0; phase = 1'b0; ocp_kill = 0; tsd_kill = 0; trip_raw = 0;
    model_reset();
    #1;
    check("R1 reset", {pos_hs, pos_ls, neg_hs, neg_ls, blank_active, chop_start}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd7351));
    do_reset(2'b00, 2'b00);

    // R4: each blanking code, window measured after a reversal
    for (int c = 0; c < 4; c++) begin
      int len;
      do_reset(c[1:0], 2'b01);
      enable = 1'b1;
      step(); step();
      phase = ~phase;
      step();
      len = 0;
      while (blank_active && len < 100) begin len++; step(); end
      check("R4 length", len, blank_len(c[1:0]));
    end

    // R6: chopping period per code
    for (int c = 0; c < 4; c++) begin
      int gap;
      do_reset(2'b01, c[1:0]);
      while (!chop_start) step();
      step();
      gap = 1;
      while (!chop_start && gap < 500) begin gap++; step(); end
      check("R6 period", gap, 8 * osc_div(c[1:0]));
    end

    // R8: trip outside blanking holds drive off until the next cycle start
    do_reset(2'b01, 2'b00);
    enable = 1'b1;
    for (int i = 0; i < 12; i++) step();
    trip_raw = 1'b1; step(); trip_raw = 1'b0;
    check("R8 latched off", {pos_hs, pos_ls, neg_hs, neg_ls}, 0);
    while (!chop_start) step();
    step();
    check("R8 released", pos_ls && neg_hs, 1);

    // R9: dead time before the new direction
    do_reset(2'b00, 2'b01);
    enable = 1'b1;
    step(); step();
    phase = 1'b1;
    step();
    for (int i = 0; i < DEAD; i++) begin
      check("R9 dead", {pos_hs, pos_ls, neg_hs, neg_ls}, 0);
      step();
    end
    check("R9 new dir", {pos_hs, neg_ls}, 2'b11);

    // random segments
    for (int s = 0; s < 40; s++) begin
      do_reset(2'($urandom), 2'($urandom));
      for (int i = 0; i < 300; i++) begin
        sleep_n  = ($urandom % 100) < 92;
        enable   = ($urandom % 100) < 88;
        if (($urandom % 100) < 6) phase = ~phase;
        ocp_kill = ($urandom % 100) < 3;
        tsd_kill = ($urandom % 100) < 3;
        trip_raw = ($urandom % 100) < 15;
        step();
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule